// File: doc/BRIEF.md
# Parallel-Capture Serial Readout Frame Register

This block is the output stage of a multi-channel front-end digitizer. Each channel supplies a time tag and a converted charge value, and all channels share an event number. On a single capture strobe the block builds one fixed-width record per channel and latches every record in the same clock. Each record holds the time tag, the channel's own index, the event number and the charge, followed by two even-parity bits.

After the capture the records form one long shift chain. The chain moves one bit per clock while the shift-enable input is high, so the whole frame leaves on a single serial data line. The frame starts with the first record's most significant bit and ends with the last record's final parity bit.

A done flag tells the downstream collector when the final bit has gone. A new capture clears the flag. A new capture also restarts the frame at any point, even in the middle of a readout. The converter and the acquisition sequencer are not part of this block. They appear only as the input buses and the strobes.

Top module: `serial_frame_readout`

## Requirements
- R1: After reset `done` and `sdata` are low. Until the first capture, `shift_en` has no effect: `done` stays low however many shift clocks are applied.
- R2: The record is 40 bits wide, most significant bit first. Bits [39:24] are the channel's time tag, [23:17] the channel index, [16:14] the shared event number, [13:2] the channel's charge, [1] the header parity bit and [0] the charge parity bit.
- R3: The channel-index field of the record for channel i holds i, for i from 0 to 87.
- R4: Both parity bits use even parity. Bit [1] makes the count of ones over bits [39:14] and bit [1] even. Bit [0] makes the count of ones over bits [13:2] and bit [0] even.
- R5: A high `load` at a clock edge captures all 88 records from the inputs present at that edge. Input changes after that edge do not alter the frame being read out.
- R6: The chain advances one bit per clock only while `shift_en` is high. While it is low, no bit is lost or repeated.
- R7: When `load` and `shift_en` are high together, the capture wins and no shift takes place. `sdata` then shows bit 39 of the new channel 0 record.
- R8: The stream order is channel 0 to channel 87, each record most significant bit first, for 88 x 40 = 3520 bits. Before the first shift `sdata` shows stream bit 0, and after k shifts it shows stream bit k.
- R9: `done` rises at the edge of the 3520th shift and stays high, whatever `shift_en` does, until the next capture.
- R10: A capture clears `done` at its edge and restarts the frame from bit 0 of the new data, including during a readout in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture strobe for all records |
| shift_en | input | 1 | Advance the chain by one bit this clock |
| time_bus | input | 1408 | Per-channel 16-bit time tags, channel i at [16i+15:16i] |
| event_num | input | 3 | Event number shared by all channels |
| charge_bus | input | 1056 | Per-channel 12-bit charges, channel i at [12i+11:12i] |
| sdata | output | 1 | Serial data, current head of the chain |
| done | output | 1 | High once the full frame has been shifted out |

## Verification
Two situations are hard to reach from the ports. One is a capture that lands in the same cycle as a shift request, in the middle of a readout. The other is a readout broken by idle gaps. The bench shifts part of one frame and then raises `load` and `shift_en` together with a different input pattern. It then reads the new frame in full and checks that it starts at bit 0. A separate readout drops `shift_en` for several cycles at intervals, and the reassembled records must still match the expected values bit for bit. The done flag is checked on the cycle before the final shift and on the cycle after it, so the 3520-bit count is pinned exactly.

// File: rtl/frame_pkg.sv
// Package: shared types for the serial readout frame register.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package frame_pkg;

    // Readout sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no frame captured yet
        ST_SHIFT = 2'd1,   // frame captured, bits remain
        ST_DONE  = 2'd2    // every bit has left the chain
    } rd_state_t;

endpackage

// File: rtl/frame_rec_pack.sv
// Module: frame_rec_pack
// Builds one channel record: time tag, channel index, event number,
// charge, header parity, charge parity (even parity, MSB first).
// Assumes: CH_IDX fits in CH_W bits; purely combinational.
module frame_rec_pack #(
    parameter int TIME_W = 16,
    parameter int CH_W   = 7,
    parameter int EVT_W  = 3,
    parameter int CHG_W  = 12,
    parameter int CH_IDX = 0,
    localparam int HDR_W = TIME_W + CH_W + EVT_W,
    localparam int REC_W = HDR_W + CHG_W + 2
) (
    input  logic [TIME_W-1:0] time_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [CHG_W-1:0]  chg_i,
    output logic [REC_W-1:0]  rec_o
);

    logic [HDR_W-1:0] hdr;
    logic             hdr_par;
    logic             chg_par;

    // Header field: time tag, fixed channel index, event number
    assign hdr     = {time_i, CH_W'(CH_IDX), evt_i};
    // Even parity bits: each equals the XOR of its field
    assign hdr_par = ^hdr;
    assign chg_par = ^chg_i;
    // Record in readout order
    assign rec_o   = {hdr, chg_i, hdr_par, chg_par};

endmodule

// File: rtl/frame_shift_chain.sv
// Module: frame_shift_chain
// Holds NUM_CH records. A load captures all of them in parallel. A shift
// moves the whole set one bit toward channel 0's MSB, which drives the
// serial output. Zeros fill in behind the last channel.
// Assumes: load_i has priority over shift_i; shift_i is already gated.
module frame_shift_chain #(
    parameter int NUM_CH = 88,
    parameter int REC_W  = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    shift_i,
    input  logic [NUM_CH*REC_W-1:0] rec_in,
    output logic                    sdata_o
);

    logic [REC_W-1:0] rec_q [NUM_CH];
    logic [NUM_CH:0]  link;   // link[g] = MSB of record g, link[NUM_CH] = fill

    assign link[NUM_CH] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_rec
            assign link[g] = rec_q[g][REC_W-1];

            // Per-record register: parallel capture or one-bit shift
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rec_q[g] <= '0;
                end else if (load_i) begin
                    rec_q[g] <= rec_in[g*REC_W +: REC_W];
                end else if (shift_i) begin
                    rec_q[g] <= {rec_q[g][REC_W-2:0], link[g+1]};
                end
            end
        end
    endgenerate

    // Serial output is the head of the chain
    assign sdata_o = link[0];

    // Captured head must equal the MSB of channel 0's input record
    assert_load_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sdata_o == $past(rec_in[REC_W-1])));

    // Without load or shift the chain head must not move
    assert_hold_without_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(sdata_o));

    // A shift brings record 0's second bit to the head
    assert_shift_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && shift_i) |=> (sdata_o == $past(rec_q[0][REC_W-2])));

endmodule

// File: rtl/frame_ctrl.sv
// Module: frame_ctrl
// Counts shifted bits, gates shift requests and raises done after
// TOTAL shifts. A load restarts the count from zero in any state.
// Assumes: TOTAL >= 2.
module frame_ctrl
    import frame_pkg::*;
#(
    parameter int TOTAL = 3520,
    localparam int CNT_W = $clog2(TOTAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic shift_en_i,
    output logic shift_o,
    output logic done_o
);

    rd_state_t        state;
    logic [CNT_W-1:0] cnt;

    // Shift only while a frame is pending and no capture is happening
    assign shift_o = (state == ST_SHIFT) && shift_en_i && !load_i;
    assign done_o  = (state == ST_DONE);

    // Sequencing: capture restarts, each shift counts, last shift finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (load_i) begin
            state <= ST_SHIFT;
            cnt   <= '0;
        end else if (shift_o) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(TOTAL - 1)) begin
                state <= ST_DONE;
            end
        end
    end

    // Capture clears done and the count
    assert_load_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!done_o && cnt == '0));

    // Done holds until the next capture
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> done_o);

    // Done implies exactly TOTAL shifts since the capture
    assert_done_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cnt == CNT_W'(TOTAL)));

    // Idle without capture never becomes done
    assert_idle_no_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load_i) |=> (state == ST_IDLE));

endmodule

// File: rtl/serial_frame_readout.sv
// Module: serial_frame_readout (top)
// Packs one record per channel, captures all of them on load and
// shifts the frame out MSB first, channel 0 first, with a done flag.
// Assumes: NUM_CH-1 fits in CH_W; buses are flat, channel i at slice i.
module serial_frame_readout #(
    parameter int NUM_CH = 88,
    parameter int TIME_W = 16,
    parameter int CH_W   = 7,
    parameter int EVT_W  = 3,
    parameter int CHG_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     shift_en,
    input  logic [NUM_CH*TIME_W-1:0] time_bus,
    input  logic [EVT_W-1:0]         event_num,
    input  logic [NUM_CH*CHG_W-1:0]  charge_bus,
    output logic                     sdata,
    output logic                     done
);

    localparam int REC_W = TIME_W + CH_W + EVT_W + CHG_W + 2;
    localparam int TOTAL = NUM_CH * REC_W;

    logic [NUM_CH*REC_W-1:0] rec_all;
    logic                    shift_go;

    // One record builder per channel
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
            frame_rec_pack #(
                .TIME_W (TIME_W),
                .CH_W   (CH_W),
                .EVT_W  (EVT_W),
                .CHG_W  (CHG_W),
                .CH_IDX (c)
            ) u_pack (
                .time_i (time_bus[c*TIME_W +: TIME_W]),
                .evt_i  (event_num),
                .chg_i  (charge_bus[c*CHG_W +: CHG_W]),
                .rec_o  (rec_all[c*REC_W +: REC_W])
            );
        end
    endgenerate

    frame_ctrl #(
        .TOTAL (TOTAL)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .shift_en_i (shift_en),
        .shift_o    (shift_go),
        .done_o     (done)
    );

    frame_shift_chain #(
        .NUM_CH (NUM_CH),
        .REC_W  (REC_W)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift_go),
        .rec_in  (rec_all),
        .sdata_o (sdata)
    );

    // Load beats shift: the head shows the new record, not a shifted bit
    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && shift_en) |=> (sdata == $past(rec_all[REC_W-1]) && !done));

endmodule

// File: tb/serial_frame_readout_bench.sv
module serial_frame_readout_bench;
    localparam int NUM_CH = 88;
    localparam int REC_W  = 40;
    localparam int TOTAL  = NUM_CH * REC_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, load = 1'b0, shift_en = 1'b0;
    logic [NUM_CH*16-1:0] time_bus;
    logic [NUM_CH*12-1:0] charge_bus;
    logic [2:0]  event_num = '0;
    logic sdata, done;

    logic [15:0] t_in [NUM_CH];
    logic [11:0] q_in [NUM_CH];
    logic [15:0] cap_t [NUM_CH];
    logic [11:0] cap_q [NUM_CH];
    logic [2:0]  cap_e;

    int checks = 0;
    int errors = 0;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            time_bus[i*16 +: 16]   = t_in[i];
            charge_bus[i*12 +: 12] = q_in[i];
        end
    end

    serial_frame_readout u_serial_frame_readout (
        .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
        .time_bus(time_bus), .event_num(event_num), .charge_bus(charge_bus),
        .sdata(sdata), .done(done)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] exp_rec(input int i);
        logic [25:0] hdr;
        hdr = {cap_t[i], 7'(i), cap_e};
        return {hdr, cap_q[i], ^hdr, ^cap_q[i]};
    endfunction

    task automatic set_pattern(input int kind);
        for (int i = 0; i < NUM_CH; i++) begin
            case (kind)
                0: begin t_in[i] = 16'(i * 16'h0123 + 7); q_in[i] = 12'(i * 37); end
                1: begin t_in[i] = 16'hFFFF; q_in[i] = 12'hFFF; end
                2: begin t_in[i] = 16'($urandom); q_in[i] = 12'($urandom); end
                default: begin t_in[i] = 16'hA5A5 ^ 16'(i); q_in[i] = 12'h3C3 ^ 12'(i); end
            endcase
        end
    endtask

    // Capture at the next edge; leaves caller at a negedge
    task automatic do_load(input logic with_shift);
        @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) begin cap_t[i] = t_in[i]; cap_q[i] = q_in[i]; end
        cap_e = event_num;
        load = 1'b1; shift_en = with_shift;
        @(negedge clk);
        load = 1'b0; shift_en = 1'b0;
    endtask

    // Read the full frame and compare record by record
    task automatic read_frame(input string req, input int pause_every);
        logic [39:0] got = '0;
        for (int k = 0; k < TOTAL; k++) begin
            got = {got[38:0], sdata};
            if (k % REC_W == REC_W - 1)
                check(got == exp_rec(k / REC_W), req, $sformatf("record %0d", k / REC_W),
                      64'(got), 64'(exp_rec(k / REC_W)));
            if (k == TOTAL - 1)
                check(done == 1'b0, "R9", "done before last shift", 64'(done), 64'd0);
            shift_en = 1'b1;
            @(negedge clk);
            if (pause_every > 0 && k % pause_every == 5) begin
                shift_en = 1'b0;
                repeat (3) @(negedge clk);
            end
        end
        shift_en = 1'b0;
        check(done == 1'b1, "R9", "done after last shift", 64'(done), 64'd1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check(sdata == 1'b0, "R1", "sdata after reset", 64'(sdata), 64'd0);
        shift_en = 1'b1;
        repeat (TOTAL + 5) @(negedge clk);
        shift_en = 1'b0;
        check(done == 1'b0, "R1", "done after shifts without capture", 64'(done), 64'd0);
    endtask

    task automatic t_basic;
        set_pattern(0); event_num = 3'd5;
        do_load(1'b0);
        check(done == 1'b0, "R10", "done after capture", 64'(done), 64'd0);
        read_frame("R2 R3 R4 R8", 0);
    endtask

    task automatic t_done_sticky;
        shift_en = 1'b1;
        repeat (50) @(negedge clk);
        shift_en = 1'b0;
        check(done == 1'b1, "R9", "done after extra shifts", 64'(done), 64'd1);
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R9", "done while idle", 64'(done), 64'd1);
    endtask

    task automatic t_pause;
        set_pattern(2); event_num = 3'd2;
        do_load(1'b0);
        check(done == 1'b0, "R10", "done cleared by capture", 64'(done), 64'd0);
        read_frame("R6 R4", 97);
    endtask

    task automatic t_input_change;
        set_pattern(1); event_num = 3'd7;
        do_load(1'b0);
        set_pattern(3); event_num = 3'd0;
        read_frame("R5", 0);
    endtask

    task automatic t_load_vs_shift;
        set_pattern(0); event_num = 3'd1;
        do_load(1'b0);
        shift_en = 1'b1;
        repeat (123) @(negedge clk);
        shift_en = 1'b0;
        set_pattern(2); event_num = 3'd6;
        do_load(1'b1);
        check(sdata == exp_rec(0)[39], "R7", "head after load with shift",
              64'(sdata), 64'(exp_rec(0)[39]));
        check(done == 1'b0, "R10", "done after mid-frame capture", 64'(done), 64'd0);
        read_frame("R7 R10", 0);
    endtask

    initial begin
        set_pattern(0);
        t_reset();
        t_basic();
        t_done_sticky();
        t_pause();
        t_input_change();
        t_load_vs_shift();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule